// File: doc/BRIEF.md
# Serial Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands one bit at a time. It produces a 2N-bit product. The datapath has five registers: a rotating multiplicand register, a multiplier register that shifts right, an upper product half, a lower product half, and a single carry flop. One full-adder cell does all of the arithmetic. Each pass over the multiplicand adds the current multiplier bit's partial product into the upper half, one bit per cycle. A single step then moves one finished bit from the upper half into the lower half.

The sequencing comes from a three-state controller (idle, inner pass, outer step) and two small loop counters. The inner counter counts the bit positions of a pass. The outer counter counts the multiplier bits. Each counter's terminal-count flag decides when the controller leaves a state. A user pulses `start` with both operands present and waits for the one-cycle `done` pulse. The product then stays on `product` until the next accepted start.

Top module: `serial_bit_multiplier`

## Requirements
- R1: While reset is asserted (rst_n low), `done` is 0 and `product` is all zeros.
- R2: At `done`, `product` equals the full unsigned product a × b over 2N bits, where a and b are the operands captured at the accepted start. The upper N bits are the upper half of the product.
- R3: `start` is accepted only when the block is idle. `done` is high for exactly one cycle, N×(N+1) clock edges after the accepting edge.
- R4: Changes on `a_in` and `b_in` after the accepting edge have no effect on the result of that multiplication.
- R5: A high `start` while a multiplication is running is ignored. It neither restarts the operation nor shifts the timing of `done`.
- R6: While idle with no start, `product` holds its last value whatever the operand inputs do.
- R7: In every inner-pass cycle, the multiplicand rotates, the adder sum enters the top of the upper half, and the multiplier register and the lower half hold.
- R8: In every outer step, the multiplier shifts right, the lower half takes the bit leaving the upper half, and the saved carry enters the top of the upper half. The carry flop is then cleared.
- R9: Each loop counter advances by one only while its count enable is high. It wraps to 0 from its terminal value N−1, and its terminal-count flag is high exactly at N−1.
- R10: The inner counter's terminal count moves the controller from the inner pass to the outer step. From the outer step, the outer counter's terminal count returns it to idle; otherwise it goes back to the inner pass. Accepting a start clears both counters, and entering the outer step clears the inner counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiplication; sampled only when idle |
| a_in | input | N | Multiplicand operand |
| b_in | input | N | Multiplier operand |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Unsigned product, upper half followed by lower half |

## Verification
Some properties are checked by assertions on every cycle: the counters' step, hold and wrap, the controller's exits on each terminal count, the one-cycle width of `done`, the holding of the multiplier and lower half during a pass, the carry insertion and clear at each outer step, and product stability while idle. The arithmetic result itself can only be shown by the bench. It covers every operand pair for N = 4, plus random runs in which the operand inputs churn and `start` is toggled throughout the operation. Those runs also show the exact latency and that late inputs are ignored.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INNER = 2'd1,
    ST_OUTER = 2'd2
  } seq_state_t;

  // Datapath control word issued by the sequencer each cycle
  typedef struct packed {
    logic shift_a;
    logic select_sum;
    logic shift_hi;
    logic shift_b;
    logic shift_low;
    logic clr_carry;
  } ctl_t;

  // One full-adder cell: returns {carry_out, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
    full_add = {(x & y) | (x & cin) | (y & cin), x ^ y ^ cin};
  endfunction

  // Counter width for a modulus
  function automatic int count_bits(input int limit);
    count_bits = (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int LIMIT = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ce,
  input  logic                                  clr,
  output logic [sbm_pkg::count_bits(LIMIT)-1:0] count,
  output logic                                  tc
);
  localparam int CW = sbm_pkg::count_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign count = cnt_q;
  assign tc    = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (ce)       cnt_q <= tc ? '0 : cnt_q + CW'(1);
  end

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr) |=> $stable(count));
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !clr && !tc) |=> (count == $past(count) + CW'(1)));
  // R9
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !clr && tc) |=> (count == '0));

endmodule

// File: rtl/serial_mul_ctrl.sv
module serial_mul_ctrl (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tc_i,
  input  logic          tc_j,
  output sbm_pkg::ctl_t ctl,
  output logic          load,
  output logic          idle,
  output logic          ce_i,
  output logic          clr_i,
  output logic          ce_j,
  output logic          clr_j,
  output logic          done
);
  import sbm_pkg::*;

  seq_state_t state_q, state_d;
  logic       in_inner, in_outer;
  logic       done_q;

  assign idle     = (state_q == ST_IDLE);
  assign in_inner = (state_q == ST_INNER);
  assign in_outer = (state_q == ST_OUTER);
  assign load     = idle && start;

  // Loop counter controls
  assign clr_i = load;
  assign ce_i  = in_outer;
  assign ce_j  = in_inner;
  assign clr_j = in_outer || load;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_INNER;
      ST_INNER: if (tc_j)  state_d = ST_OUTER;
      ST_OUTER: state_d = tc_i ? ST_IDLE : ST_INNER;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.shift_a    = in_inner;
    ctl.select_sum = in_inner;
    ctl.shift_hi   = in_inner || in_outer;
    ctl.shift_b    = in_outer;
    ctl.shift_low  = in_outer;
    ctl.clr_carry  = in_outer;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= in_outer && tc_i;
    end
  end

  assign done = done_q;

  // R10
  j_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_inner && tc_j) |=> (state_q == ST_OUTER));
  // R10
  i_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_outer && tc_i) |=> (idle && done));
  // R10
  outer_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_outer && !tc_i) |=> in_inner);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && start && !(in_outer && tc_i)) |=> !idle);
  // R10
  ctl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_inner, in_outer, idle}) && (state_q != 2'd3));

endmodule

// File: rtl/serial_mul_dp.sv
module serial_mul_dp #(
  parameter int N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            idle,
  input  logic [N-1:0]    a_in,
  input  logic [N-1:0]    b_in,
  input  sbm_pkg::ctl_t   ctl,
  output logic [2*N-1:0]  product
);
  import sbm_pkg::*;

  logic [N-1:0] a_q, b_q, hi_q, low_q;
  logic         carry_q;
  logic [1:0]   fa;
  logic         sum_bit, carry_out, hi_fill;

  // Bit leaving HI plus the current partial-product bit plus the saved carry
  assign fa        = full_add(hi_q[0], a_q[0] & b_q[0], carry_q);
  assign sum_bit   = fa[0];
  assign carry_out = fa[1];
  // Pass bit during a pass; the saved overflow carry during the outer step
  assign hi_fill   = ctl.select_sum ? sum_bit : carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      hi_q    <= '0;
      low_q   <= '0;
      carry_q <= 1'b0;
    end else if (load) begin
      a_q     <= a_in;
      b_q     <= b_in;
      hi_q    <= '0;
      low_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ctl.shift_a)   a_q   <= {a_q[0], a_q[N-1:1]};
      if (ctl.shift_b)   b_q   <= {1'b0, b_q[N-1:1]};
      if (ctl.shift_hi)  hi_q  <= {hi_fill, hi_q[N-1:1]};
      if (ctl.shift_low) low_q <= {hi_q[0], low_q[N-1:1]};
      if (ctl.clr_carry)       carry_q <= 1'b0;
      else if (ctl.select_sum) carry_q <= carry_out;
    end
  end

  assign product = {hi_q, low_q};

  initial begin
    n_min_chk: assert (N >= 2);
  end

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.select_sum && !load) |=> ($stable(b_q) && $stable(low_q)));
  // R8
  outer_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shift_low && !load) |=> (!carry_q && hi_q[N-1] == $past(carry_q)));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !load) |=> $stable(product));

endmodule

// File: rtl/serial_bit_multiplier.sv
module serial_bit_multiplier #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic           done,
  output logic [2*N-1:0] product
);
  import sbm_pkg::*;

  localparam int CW = count_bits(N);

  ctl_t          ctl;
  logic          load, idle;
  logic          ce_i, clr_i, tc_i;
  logic          ce_j, clr_j, tc_j;
  logic [CW-1:0] cnt_i, cnt_j;

  serial_mul_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .tc_i  (tc_i),
    .tc_j  (tc_j),
    .ctl   (ctl),
    .load  (load),
    .idle  (idle),
    .ce_i  (ce_i),
    .clr_i (clr_i),
    .ce_j  (ce_j),
    .clr_j (clr_j),
    .done  (done)
  );

  loop_counter #(.LIMIT(N)) u_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_i),
    .clr   (clr_i),
    .count (cnt_i),
    .tc    (tc_i)
  );

  loop_counter #(.LIMIT(N)) u_cnt_j (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_j),
    .clr   (clr_j),
    .count (cnt_j),
    .tc    (tc_j)
  );

  serial_mul_dp #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .idle    (idle),
    .a_in    (a_in),
    .b_in    (b_in),
    .ctl     (ctl),
    .product (product)
  );

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_i == '0 && cnt_j == '0));
  // R10
  outer_jclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.shift_b |=> (cnt_j == '0));
  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_i) < N) && (int'(cnt_j) < N));

endmodule

// File: tb/serial_bit_multiplier_test.sv
module serial_bit_multiplier_test;
  localparam int N          = 4;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = N * (N + 1);
  localparam int WATCHDOG   = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   a_in = '0;
  logic [N-1:0]   b_in = '0;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  serial_bit_multiplier #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_in    (a_in),
    .b_in    (b_in),
    .done    (done),
    .product (product)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Reference: repeated addition, wide enough for the full product
  function automatic logic [2*N-1:0] ref_product(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [2*N-1:0] acc = '0;
    for (int k = 0; k < int'(y); k++) acc = acc + (2*N)'(x);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One multiplication; garble churns operands, spam toggles start while busy
  task automatic run_case(input logic [N-1:0] x, input logic [N-1:0] y,
                          input bit garble, input bit spam, input string tag);
    logic [2*N-1:0] exp = ref_product(x, y);
    logic [2*N-1:0] held;
    int cnt = 0;
    @(negedge clk);
    a_in  = x;
    b_in  = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt <= LAT + 4) begin
      if (garble) begin
        a_in = N'($urandom);
        b_in = N'($urandom);
      end
      if (spam) start = 1'($urandom);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    // R3 latency from the accepting edge
    check(cnt == LAT, "R3 done latency", cnt, LAT);
    check(product == exp, tag, product, exp);
    held = product;
    // R6: product holds while idle and operands move
    for (int k = 0; k < 2; k++) begin
      a_in = N'($urandom);
      b_in = N'($urandom);
      @(negedge clk);
      if (k == 0) check(done == 1'b0, "R3 done width", done, 0);
      check(product == held, "R6 idle hold", product, held);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(product == '0, "R1 reset product", product, 0);
    rst_n = 1'b1;

    // Directed corners (R2)
    run_case('0, '0, 1'b0, 1'b0, "R2 zero operands");
    run_case('1, '1, 1'b0, 1'b0, "R2 both max");
    run_case('1, N'(1), 1'b0, 1'b0, "R2 max times one");
    run_case(N'(1), '1, 1'b0, 1'b0, "R2 one times max");
    run_case(N'(1) << (N - 1), N'(1) << (N - 1), 1'b0, 1'b0, "R2 top bits");
    run_case('0, '1, 1'b0, 1'b0, "R2 zero times max");

    // Exhaustive sweep (R2)
    for (int x = 0; x < (1 << N); x++)
      for (int y = 0; y < (1 << N); y++)
        run_case(N'(x), N'(y), 1'b0, 1'b0, "R2 exhaustive product");

    // Operand churn during the run (R4)
    for (int r = 0; r < 30; r++)
      run_case(N'($urandom), N'($urandom), 1'b1, 1'b0, "R4 late operands ignored");

    // Start toggled while busy (R5), with churn too
    for (int r = 0; r < 30; r++)
      run_case(N'($urandom), N'($urandom), 1'($urandom), 1'b1, "R5 busy start ignored");

    run_case('1, '1, 1'b1, 1'b1, "R5 max with churn and start spam");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule